// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the address sequence for a multi-word load or store. A start pulse hands it a base address, a 16-bit mask naming the registers to move, one of four addressing modes, and a writeback choice. It then puts out one register index with its word address for each register named in the mask, one pair per accepted handshake toward the memory port. Registers go out in ascending index order. The lowest-numbered register always gets the lowest address, whichever direction the mode selects.

After the last pair is accepted, the block raises a one-cycle completion pulse and presents the updated base. The caller writes that base back to its register file. Data movement and the register file belong to the surrounding logic.

Top module: `lsm_addr_seq`

## Requirements
- R1: While reset is held (rst_n low) and in the first cycle after release, neither xferValid nor donePulse is high.
- R2: A start pulse seen in the idle state with a non-empty mask makes xferValid go high in the next cycle. The block issues exactly one (xferReg, xferAddr) pair for each set bit of regMask. xferReg is the bit index, and the pairs come in ascending bit order. The block moves to the next pair only after a cycle with xferValid and xferReady both high.
- R3: With addrMode 0 (increment, step after), the first pair uses baseAddr, and each later pair's address is 4 above the one before it.
- R4: With addrMode 1 (increment, step before), the first pair uses baseAddr+4, and later addresses rise by 4.
- R5: With addrMode 2 (decrement, step after), the last (highest) pair uses baseAddr, and lower registers sit 4 bytes apart below it. The first address is baseAddr-4*(n-1), where n is the number of set mask bits.
- R6: With addrMode 3 (decrement, step before), the highest pair uses baseAddr-4. The first address is baseAddr-4*n.
- R7: While xferValid is high and xferReady is low, xferReg and xferAddr hold their values.
- R8: donePulse is high for exactly one cycle. That cycle is the one after the last pair is accepted, and xferValid is low in it.
- R9: In the donePulse cycle, newBase is baseAddr+4*n for modes 0 and 1 and baseAddr-4*n for modes 2 and 3 when writeBack is 1, and baseAddr when writeBack is 0. All address arithmetic wraps modulo 2^32.
- R10: A start with regMask equal to 0 raises donePulse in the next cycle and issues no pair. newBase then equals baseAddr.
- R11: A start pulse that arrives while a transfer sequence is in progress is ignored. The running sequence and its final newBase are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a sequence when the block is idle |
| baseAddr | input | 32 | Base address, sampled at start |
| regMask | input | 16 | Register list, bit i names register i |
| addrMode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| writeBack | input | 1 | 1 moves the base by the transfer span |
| xferValid | output | 1 | A register/address pair is offered |
| xferReady | input | 1 | Memory port accepts the offered pair |
| xferReg | output | 4 | Register index of the offered pair |
| xferAddr | output | 32 | Word address of the offered pair |
| donePulse | output | 1 | One-cycle completion strobe |
| newBase | output | 32 | Updated base, valid with donePulse |

## Verification
The memory port can accept a pair in the same cycle that a new start pulse arrives, including acceptance of the final pair. The bench provokes this by holding startPulse high, with a different mask, base and mode, through every cycle of a running sequence while xferReady follows a pseudo-random stall pattern. The result is judged correct only if every issued pair, the completion cycle and newBase match the values computed from the original request, and the ignored request leaves no trace in the following sequence.

// File: rtl/lsm_seq_pkg.sv
package lsm_seq_pkg;

  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'd0,
    MODE_INC_BEFORE = 2'd1,
    MODE_DEC_AFTER  = 2'd2,
    MODE_DEC_BEFORE = 2'd3
  } seqMode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic inputEmpty;
    logic lastOne;
  } seqStatus_t;

endpackage

// File: rtl/lsm_seq_ctrl.sv
module lsm_seq_ctrl
  import lsm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startPulse,
  input  logic       xferReady,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       xferValid,
  output logic       donePulse
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strobe.load    = 1'b0;
    strobe.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.load = 1'b1;
          stateNext   = status.inputEmpty ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        if (xferReady) begin
          strobe.advance = 1'b1;
          if (status.lastOne) stateNext = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign xferValid = (state == ST_RUN);
  assign donePulse = (state == ST_DONE);

endmodule

// File: rtl/lsm_seq_dpath.sv
module lsm_seq_dpath
  import lsm_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(LIST_W),
  localparam int CNT_W     = $clog2(LIST_W + 1),
  localparam int STEP_SH   = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [LIST_W-1:0] regMask,
  input  logic [1:0]        addrMode,
  input  logic              writeBack,
  output seqStatus_t        status,
  output logic [IDX_W-1:0]  xferReg,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [ADDR_W-1:0] newBase
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [LIST_W-1:0] remMask;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] finalBase;

  logic [CNT_W-1:0]  regCount;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] firstAddr;
  logic [ADDR_W-1:0] baseNext;
  logic [LIST_W-1:0] remDrop;
  seqMode_t          mode;

  assign mode = seqMode_t'(addrMode);

  // population count of the incoming list
  always_comb begin
    regCount = '0;
    for (int i = 0; i < LIST_W; i++) regCount = regCount + CNT_W'(regMask[i]);
  end

  assign span = ADDR_W'(regCount) << STEP_SH;

  // lowest address of the block, then walked upward
  always_comb begin
    unique case (mode)
      MODE_INC_AFTER:  firstAddr = baseAddr;
      MODE_INC_BEFORE: firstAddr = baseAddr + STEP;
      MODE_DEC_AFTER:  firstAddr = baseAddr - span + STEP;
      MODE_DEC_BEFORE: firstAddr = baseAddr - span;
      default:         firstAddr = baseAddr;
    endcase
  end

  always_comb begin
    if (!writeBack)      baseNext = baseAddr;
    else if (addrMode[1]) baseNext = baseAddr - span;
    else                 baseNext = baseAddr + span;
  end

  // lowest set bit of the remaining list
  always_comb begin
    xferReg = '0;
    for (int i = LIST_W - 1; i >= 0; i--) begin
      if (remMask[i]) xferReg = IDX_W'(i);
    end
  end

  assign remDrop = remMask & (remMask - LIST_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remMask   <= '0;
      curAddr   <= '0;
      finalBase <= '0;
    end else if (strobe.load) begin
      remMask   <= regMask;
      curAddr   <= firstAddr;
      finalBase <= baseNext;
    end else if (strobe.advance) begin
      remMask   <= remDrop;
      curAddr   <= curAddr + STEP;
    end
  end

  assign status.inputEmpty = (regMask == '0);
  assign status.lastOne    = (remDrop == '0);
  assign xferAddr          = curAddr;
  assign newBase           = finalBase;

endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [LIST_W-1:0] regMask,
  input  logic [1:0]        addrMode,
  input  logic              writeBack,
  output logic              xferValid,
  input  logic              xferReady,
  output logic [IDX_W-1:0]  xferReg,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              donePulse,
  output logic [ADDR_W-1:0] newBase
);

  seqStrobe_t strobe;
  seqStatus_t status;

  lsm_seq_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .xferReady  (xferReady),
    .status     (status),
    .strobe     (strobe),
    .xferValid  (xferValid),
    .donePulse  (donePulse)
  );

  lsm_seq_dpath #(
    .ADDR_W     (ADDR_W),
    .LIST_W     (LIST_W),
    .WORD_BYTES (WORD_BYTES)
  ) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .baseAddr  (baseAddr),
    .regMask   (regMask),
    .addrMode  (addrMode),
    .writeBack (writeBack),
    .status    (status),
    .xferReg   (xferReg),
    .xferAddr  (xferAddr),
    .newBase   (newBase)
  );

endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xferValid,
  input logic              xferReady,
  input logic [IDX_W-1:0]  xferReg,
  input logic [ADDR_W-1:0] xferAddr,
  input logic              donePulse
);

  // R7: offered pair holds while stalled
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xferValid && !xferReady) |=> (xferValid && $stable(xferReg) && $stable(xferAddr)));

  // R2: next pair in a sequence carries a higher register index
  assert_reg_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xferValid && xferReady) |=> (!xferValid || (xferReg > $past(xferReg))));

  // R3: consecutive pairs are one word apart
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xferValid && xferReady) |=> (!xferValid || (xferAddr == $past(xferAddr) + ADDR_W'(4))));

  // R8: completion never overlaps an offer and lasts one cycle
  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |-> !xferValid);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |=> !donePulse);

  // R8: completion follows an accepted pair or a start, never a stall
  assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xferValid && !xferReady) |=> !donePulse);

endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .xferValid (xferValid),
  .xferReady (xferReady),
  .xferReg   (xferReg),
  .xferAddr  (xferAddr),
  .donePulse (donePulse)
);

// File: tb/lsm_addr_seq_tb_top.sv
`timescale 1ns/1ps
module lsm_addr_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [15:0] regMask = '0;
  logic [1:0]  addrMode = '0;
  logic        writeBack = 1'b0;
  logic        xferValid;
  logic        xferReady = 1'b0;
  logic [3:0]  xferReg;
  logic [31:0] xferAddr;
  logic        donePulse;
  logic [31:0] newBase;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  lsm_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .baseAddr(baseAddr),
    .regMask(regMask), .addrMode(addrMode), .writeBack(writeBack),
    .xferValid(xferValid), .xferReady(xferReady), .xferReg(xferReg),
    .xferAddr(xferAddr), .donePulse(donePulse), .newBase(newBase)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsrStep(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic runOp(input logic [1:0] m, input bit wb, input logic [15:0] mask,
                       input logic [31:0] b, input bit stall, input bit noise);
    int n = 0;
    int k = 0;
    logic [31:0] low, nb, expA;
    bit rdy;
    string modeReq;
    for (int i = 0; i < 16; i++) n += int'(mask[i]);
    case (m)
      2'd0: begin low = b;                          modeReq = "R3"; end
      2'd1: begin low = b + 32'd4;                  modeReq = "R4"; end
      2'd2: begin low = b - 32'(4 * n) + 32'd4;     modeReq = "R5"; end
      default: begin low = b - 32'(4 * n);          modeReq = "R6"; end
    endcase
    if (!wb)       nb = b;
    else if (m[1]) nb = b - 32'(4 * n);
    else           nb = b + 32'(4 * n);

    @(negedge clk);
    startPulse = 1'b1; addrMode = m; writeBack = wb; regMask = mask; baseAddr = b;
    xferReady = 1'b0;
    @(negedge clk);
    startPulse = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (mask[i]) begin
        expA = low + 32'(4 * k);
        do begin
          rdy = stall ? lfsr[0] : 1'b1;
          lfsr = lfsrStep(lfsr);
          xferReady = rdy;
          // R11: unrelated start request during the run
          startPulse = noise;
          if (noise) begin
            regMask = ~mask; baseAddr = b ^ 32'h1234_5670; addrMode = ~m; writeBack = ~wb;
          end
          chk(xferValid == 1'b1, "R2 valid", 32'(xferValid), 32'd1);
          chk(xferReg == 4'(i), "R2 reg", 32'(xferReg), 32'(i));
          chk(xferAddr == expA, noise ? "R11 addr" : modeReq, xferAddr, expA);
          chk(donePulse == 1'b0, "R8 early done", 32'(donePulse), 32'd0);
          @(negedge clk);
        end while (!rdy);
        k++;
      end
    end
    startPulse = 1'b0; xferReady = 1'b0;
    chk(donePulse == 1'b1, (n == 0) ? "R10 done" : "R8 done", 32'(donePulse), 32'd1);
    chk(xferValid == 1'b0, "R8 valid at done", 32'(xferValid), 32'd0);
    chk(newBase == nb, noise ? "R11 base" : ((n == 0) ? "R10 base" : "R9"), newBase, nb);
    @(negedge clk);
    chk(donePulse == 1'b0, "R8 single", 32'(donePulse), 32'd0);
    chk(xferValid == 1'b0, (n == 0) ? "R10 no xfer" : "R11 idle", 32'(xferValid), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] masks [0:27];
    logic [15:0] rnd = 16'h5A3C;
    masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'h8001;
    masks[3] = 16'hAAAA; masks[4] = 16'h5555; masks[5] = 16'hF00F;
    for (int i = 0; i < 16; i++) masks[6 + i] = 16'(1) << i;
    for (int i = 22; i < 28; i++) begin
      rnd = lfsrStep(lfsrStep(lfsrStep(rnd)));
      masks[i] = rnd;
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(xferValid == 1'b0, "R1 valid", 32'(xferValid), 32'd0);
    chk(donePulse == 1'b0, "R1 done", 32'(donePulse), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(xferValid == 1'b0, "R1 valid after", 32'(xferValid), 32'd0);
    chk(donePulse == 1'b0, "R1 done after", 32'(donePulse), 32'd0);

    for (int m = 0; m < 4; m++) begin
      for (int wb = 0; wb < 2; wb++) begin
        for (int j = 0; j < 28; j++) begin
          logic [31:0] b;
          bit noise;
          // bases include ones near zero and the top so arithmetic wraps
          case (j % 4)
            0: b = 32'h0000_0000;
            1: b = 32'hFFFF_FFFC;
            2: b = 32'h2000_0100 + 32'(j * 64);
            default: b = 32'h0000_0040;
          endcase
          noise = (j % 3 == 1) && (masks[j] != 16'h0);
          runOp(2'(m), wb[0], masks[j], b, (j % 2) == 1, noise);
        end
      end
    end

    // R7: long stall on a full list
    runOp(2'd3, 1'b1, 16'hFFFF, 32'h0001_0000, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule